// File: doc/BRIEF.md
# VPW Frame Validity and CRC Checker

This block sits behind a variable-pulse-width symbol decoder on a single-wire vehicle network receiver. Each clock cycle the decoder may hand it one symbol: start of frame, a data bit of value 0 or 1, the end-of-data event, the end-of-frame event, a normalization bit, a break, or a reserved code. The checker packs data bits into bytes, most significant bit first, and emits each completed byte with a one-cycle strobe. It keeps a running CRC-8 over every data bit of the current segment, and it enforces the frame grammar.

A segment is the main message, which opens with start of frame, or an in-frame response, which opens with a normalization bit after the first end of data. At each valid end of data the CRC remainder is compared with a fixed residue. When the check fails, the block raises a CRC-error pulse. When the grammar is broken, it raises an invalid-frame pulse instead. After either error, and after a break, the receiver is held disabled and ignores every symbol until the next end-of-frame event. Error pulses are suppressed while the link is in a quiet (sleep or filter) mode and the local node is not transmitting.

Top module: `vpw_frame_checker`

## Requirements
- R1: After reset every output is low and the block waits for start of frame. Symbol codes on `sym_code`, taken only when `sym_valid` is high: 0 start of frame, 1 data bit 0, 2 data bit 1, 3 end of data, 4 end of frame, 5 normalization bit, 6 break, 7 reserved and always ignored.
- R2: Accepted data bits are packed MSB first, so the first bit of a byte lands in bit 7 of `byte_data`. `byte_valid` is high for exactly the one cycle after the edge that takes the eighth bit, with `byte_data` holding the byte.
- R3: The CRC starts at 0xFF at start of frame and shifts each data bit MSB first with polynomial 0x1D. When end of data follows one or more whole bytes, a remainder other than 0xC4 makes `crc_err` pulse high in the cycle after the end-of-data symbol.
- R4: After the first end of data, a normalization bit opens a response segment. That segment restarts the CRC at 0xFF and is checked again at its own end of data.
- R5: Start of frame received after an end of data but before end of frame makes `inv_frame` pulse.
- R6: Start of frame or a normalization bit received while data bits are expected makes `inv_frame` pulse.
- R7: With `len_unlimited` low, the first bit of a 13th byte in one frame (12 bytes plus one bit, message and response counted together) makes `inv_frame` pulse and that bit is dropped. With `len_unlimited` high, the 13th byte is accepted.
- R8: End of data while data bits are still expected (a partial byte, or no byte yet in the segment) makes `inv_frame` pulse.
- R9: A data bit received while start of frame is expected (idle, or after an end of data without a normalization bit) makes `inv_frame` pulse.
- R10: After the second end of data in a frame, any symbol other than end of frame or break makes `inv_frame` pulse.
- R11: Any error sets `rx_disabled` in the same cycle as its pulse. While it is set, no byte is emitted and no further error is reported. It clears in the cycle after an end-of-frame symbol, so each frame reports at most one error.
- R12: A break sets `rx_disabled` in the cycle after it, from any state, without raising `crc_err` or `inv_frame`. End of frame clears it.
- R13: While `quiet_mode` is high and `tx_active` is low, `crc_err` and `inv_frame` stay low. The lockout to end of frame still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A symbol is offered this cycle |
| sym_code | input | 3 | Symbol code (see R1) |
| len_unlimited | input | 1 | 1 removes the 12-byte frame limit |
| quiet_mode | input | 1 | Sleep or filter mode is active |
| tx_active | input | 1 | Local node is transmitting |
| byte_valid | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Last completed byte |
| crc_err | output | 1 | One-cycle CRC error pulse |
| inv_frame | output | 1 | One-cycle invalid frame pulse |
| rx_disabled | output | 1 | Receiver locked out until end of frame |

## Verification
Every result is one register away from its cause. `byte_valid` and `byte_data` follow the edge that takes the eighth bit. `crc_err`, `inv_frame` and a rising `rx_disabled` follow the edge that takes the offending symbol, and `rx_disabled` falls after the edge that takes end of frame. The bench drives each symbol on a falling edge, holds it for one rising edge, and samples all outputs 1 ns after that edge. Each symbol's effect is therefore checked in the exact cycle it is due. Sticky tallies collected over whole segments show that pulses are absent where a requirement says nothing may happen.

// File: rtl/vpw_chk_pkg.sv
// Shared symbol codes and controller states for the VPW frame checker.
// Assumes the symbol decoder uses the 3-bit code set listed here.
package vpw_chk_pkg;
    typedef enum logic [2:0] {
        SYM_SOF  = 3'd0,
        SYM_BIT0 = 3'd1,
        SYM_BIT1 = 3'd2,
        SYM_EOD  = 3'd3,
        SYM_EOF  = 3'd4,
        SYM_NB   = 3'd5,
        SYM_BRK  = 3'd6,
        SYM_RSV  = 3'd7
    } sym_e;

    typedef enum logic [2:0] {
        FS_IDLE = 3'd0,   // waiting for start of frame
        FS_DATA = 3'd1,   // data bits expected
        FS_EOD1 = 3'd2,   // after first end of data
        FS_EOD2 = 3'd3,   // after second end of data, end of frame required
        FS_LOCK = 3'd4    // receiver disabled until end of frame
    } fstate_e;
endpackage

// File: rtl/vpw_bit_packer.sv
// Packs accepted data bits into bytes, MSB first.
// Assumes at most one bit per cycle; clr restarts the bit count.
module vpw_bit_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      bit_en,
    input  logic                      bit_val,
    output logic [$clog2(BYTE_W)-1:0] bit_cnt,
    output logic                      byte_valid,
    output logic [BYTE_W-1:0]         byte_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;

    // Shift bits in and publish a byte after the last bit of each group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (clr) begin
                bit_cnt <= '0;
            end else if (bit_en) begin
                if (bit_cnt == LAST) begin
                    byte_data  <= {shreg, bit_val};
                    byte_valid <= 1'b1;
                    bit_cnt    <= '0;
                end else begin
                    shreg   <= {shreg[BYTE_W-3:0], bit_val};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vpw_crc_unit.sv
// Bit-serial CRC register, MSB first, with a synchronous restart.
// Assumes one data bit per cycle at most.
module vpw_crc_unit #(
    parameter int           CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 8'h1D,
    parameter logic [CRC_W-1:0] INIT  = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bit_en,
    input  logic             bit_val,
    output logic [CRC_W-1:0] crc
);
    logic             fb;
    logic [CRC_W-1:0] crc_next;

    // Compute the remainder after one more bit.
    always_comb begin
        fb       = crc[CRC_W-1] ^ bit_val;
        crc_next = {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc <= INIT;
        else if (restart) crc <= INIT;
        else if (bit_en)  crc <= crc_next;
    end
endmodule

// File: rtl/vpw_frame_ctrl.sv
// Frame grammar controller. It decides which symbols are legal, accepts
// data bits, triggers CRC checks, and reports one error per frame.
// Assumes the symbol decoder delivers at most one symbol per cycle.
module vpw_frame_ctrl
    import vpw_chk_pkg::*;
#(
    parameter int           BYTE_W      = 8,
    parameter int           MAX_BYTES   = 12,
    parameter int           CRC_W       = 8,
    parameter logic [CRC_W-1:0] CRC_RESIDUE = 8'hC4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sym_valid,
    input  logic [2:0]                sym_code,
    input  logic                      len_unlimited,
    input  logic                      quiet_mode,
    input  logic                      tx_active,
    input  logic [$clog2(BYTE_W)-1:0] bit_cnt,
    input  logic [CRC_W-1:0]          crc,
    output logic                      bit_accept,
    output logic                      bit_val,
    output logic                      seg_start,
    output logic                      crc_err,
    output logic                      inv_frame,
    output logic                      rx_disabled
);
    localparam int BC_W = $clog2(MAX_BYTES + 2);
    localparam logic [BC_W-1:0] BC_MAX = BC_W'(MAX_BYTES);
    localparam logic [BC_W-1:0] BC_SAT = BC_W'(MAX_BYTES + 1);
    localparam logic [$clog2(BYTE_W)-1:0] LAST_BIT = $clog2(BYTE_W)'(BYTE_W - 1);

    fstate_e        st, nxt;
    sym_e           sym;
    logic           in_resp, seg_has, resp_start;
    logic [BC_W-1:0] byte_cnt;
    logic           bad_inv, bad_crc, report, is_bit, byte_end;

    assign sym      = sym_e'(sym_code);
    assign is_bit   = (sym == SYM_BIT0) || (sym == SYM_BIT1);
    assign bit_val  = (sym == SYM_BIT1);
    assign report   = !(quiet_mode && !tx_active);
    assign byte_end = bit_accept && (bit_cnt == LAST_BIT);

    // Next state and per-symbol verdict.
    always_comb begin
        nxt        = st;
        bit_accept = 1'b0;
        seg_start  = 1'b0;
        resp_start = 1'b0;
        bad_inv    = 1'b0;
        bad_crc    = 1'b0;
        if (sym_valid && sym != SYM_RSV) begin
            if (sym == SYM_EOF) begin
                nxt = FS_IDLE;
            end else if (sym == SYM_BRK) begin
                nxt = FS_LOCK;
            end else begin
                case (st)
                    FS_IDLE: begin
                        if (sym == SYM_SOF) begin
                            nxt       = FS_DATA;
                            seg_start = 1'b1;
                        end else if (is_bit) begin
                            bad_inv = 1'b1;
                        end
                    end
                    FS_DATA: begin
                        if (is_bit) begin
                            if (!len_unlimited && byte_cnt >= BC_MAX && bit_cnt == '0)
                                bad_inv = 1'b1;
                            else
                                bit_accept = 1'b1;
                        end else if (sym == SYM_SOF || sym == SYM_NB) begin
                            bad_inv = 1'b1;
                        end else if (sym == SYM_EOD) begin
                            if (bit_cnt != '0 || !seg_has) begin
                                bad_inv = 1'b1;
                            end else begin
                                bad_crc = (crc != CRC_RESIDUE);
                                nxt     = in_resp ? FS_EOD2 : FS_EOD1;
                            end
                        end
                    end
                    FS_EOD1: begin
                        if (sym == SYM_NB) begin
                            nxt        = FS_DATA;
                            seg_start  = 1'b1;
                            resp_start = 1'b1;
                        end else if (sym == SYM_EOD) begin
                            nxt = FS_EOD2;
                        end else begin
                            bad_inv = 1'b1;
                        end
                    end
                    FS_EOD2: bad_inv = 1'b1;
                    default: ;
                endcase
                if (bad_inv || bad_crc) nxt = FS_LOCK;
            end
        end
    end

    // State and frame bookkeeping registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= FS_IDLE;
            in_resp  <= 1'b0;
            seg_has  <= 1'b0;
            byte_cnt <= '0;
        end else begin
            st <= nxt;
            if (seg_start) begin
                in_resp <= resp_start;
                seg_has <= 1'b0;
            end else if (byte_end) begin
                seg_has <= 1'b1;
            end
            if (seg_start && !resp_start)
                byte_cnt <= '0;
            else if (byte_end && byte_cnt != BC_SAT)
                byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // Error pulses, gated by the quiet-mode rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_err   <= 1'b0;
            inv_frame <= 1'b0;
        end else begin
            crc_err   <= bad_crc && report;
            inv_frame <= bad_inv && report;
        end
    end

    assign rx_disabled = (st == FS_LOCK);
endmodule

// File: rtl/vpw_frame_checker.sv
// Top of the VPW frame checker: byte packer, CRC register and grammar
// controller. Assumes symbols come from an upstream pulse-width decoder.
module vpw_frame_checker #(
    parameter int           BYTE_W      = 8,
    parameter int           MAX_BYTES   = 12,
    parameter int           CRC_W       = 8,
    parameter logic [CRC_W-1:0] CRC_POLY    = 8'h1D,
    parameter logic [CRC_W-1:0] CRC_INIT    = 8'hFF,
    parameter logic [CRC_W-1:0] CRC_RESIDUE = 8'hC4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  logic [2:0]        sym_code,
    input  logic              len_unlimited,
    input  logic              quiet_mode,
    input  logic              tx_active,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              crc_err,
    output logic              inv_frame,
    output logic              rx_disabled
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0] bit_cnt;
    logic [CRC_W-1:0] crc;
    logic             bit_accept, bit_val, seg_start;

    vpw_frame_ctrl #(
        .BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES),
        .CRC_W(CRC_W), .CRC_RESIDUE(CRC_RESIDUE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sym_valid(sym_valid), .sym_code(sym_code),
        .len_unlimited(len_unlimited), .quiet_mode(quiet_mode),
        .tx_active(tx_active), .bit_cnt(bit_cnt), .crc(crc),
        .bit_accept(bit_accept), .bit_val(bit_val), .seg_start(seg_start),
        .crc_err(crc_err), .inv_frame(inv_frame), .rx_disabled(rx_disabled)
    );

    vpw_bit_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(seg_start),
        .bit_en(bit_accept), .bit_val(bit_val),
        .bit_cnt(bit_cnt), .byte_valid(byte_valid), .byte_data(byte_data)
    );

    vpw_crc_unit #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n), .restart(seg_start),
        .bit_en(bit_accept), .bit_val(bit_val), .crc(crc)
    );
endmodule

// File: rtl/vpw_frame_checker_chk.sv
// Port-level assertions for the VPW frame checker, bound to the top.
module vpw_frame_checker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid,
    input logic [2:0] sym_code,
    input logic       quiet_mode,
    input logic       tx_active,
    input logic       byte_valid,
    input logic       crc_err,
    input logic       inv_frame,
    input logic       rx_disabled
);
    logic is_eof, is_brk;
    assign is_eof = sym_valid && (sym_code == 3'd4);
    assign is_brk = sym_valid && (sym_code == 3'd6);

    AST_ERR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err || inv_frame) |-> rx_disabled); // R11
    AST_ONE_ERR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_err && inv_frame)); // R11
    AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_disabled && !is_eof) |=> (!crc_err && !inv_frame && !byte_valid)); // R11
    AST_EOF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        is_eof |=> !rx_disabled); // R11
    AST_BRK_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_brk |=> (rx_disabled && !crc_err && !inv_frame)); // R12
    AST_QUIET_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_mode && !tx_active) |=> (!crc_err && !inv_frame)); // R13
    AST_BYTE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R2
endmodule

bind vpw_frame_checker vpw_frame_checker_chk u_chk (.*);

// File: tb/vpw_frame_checker_test.sv
// Directed bench for the VPW frame checker.
module vpw_frame_checker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [2:0] sym_code = 3'd0;
    logic       len_unlimited = 1'b0;
    logic       quiet_mode = 1'b0;
    logic       tx_active = 1'b0;
    logic       byte_valid, crc_err, inv_frame, rx_disabled;
    logic [7:0] byte_data;

    localparam logic [2:0] C_SOF = 3'd0, C_B0 = 3'd1, C_B1 = 3'd2, C_EOD = 3'd3,
                           C_EOF = 3'd4, C_NB = 3'd5, C_BRK = 3'd6;

    int n_vec = 0, n_bad = 0;
    int seen_crc = 0, seen_inv = 0, seen_bv = 0;
    logic       c_bv, c_crc, c_inv, c_dis;
    logic [7:0] c_bd;
    logic [7:0] buf8 [0:15];
    bit         done = 0;

    always #10 clk = ~clk;

    vpw_frame_checker uut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
        .len_unlimited(len_unlimited), .quiet_mode(quiet_mode), .tx_active(tx_active),
        .byte_valid(byte_valid), .byte_data(byte_data), .crc_err(crc_err),
        .inv_frame(inv_frame), .rx_disabled(rx_disabled)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ b[i]) r = {r[6:0], 1'b0} ^ 8'h1D;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    task automatic clr_seen();
        seen_crc = 0; seen_inv = 0; seen_bv = 0;
    endtask

    // One symbol: driven on a falling edge, sampled 1 ns after the next rising edge.
    task automatic put_sym(input logic [2:0] code);
        @(negedge clk);
        sym_valid = 1'b1;
        sym_code  = code;
        @(posedge clk);
        #1;
        c_bv = byte_valid; c_bd = byte_data; c_crc = crc_err;
        c_inv = inv_frame; c_dis = rx_disabled;
        if (c_bv) seen_bv++;
        if (c_crc) seen_crc++;
        if (c_inv) seen_inv++;
        sym_valid = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_sym(b[i] ? C_B1 : C_B0);
    endtask

    // Sends buf8[0..n-1] and a CRC byte; returns the expected remainder.
    task automatic put_seg(input int n, input bit corrupt, output logic [7:0] rem);
        logic [7:0] c = 8'hFF;
        logic [7:0] cb;
        for (int i = 0; i < n; i++) begin
            put_byte(buf8[i]);
            chk(c_bv && c_bd == buf8[i], "R2 byte strobe", {c_bv, c_bd}, {1'b1, buf8[i]});
            c = crc_byte(c, buf8[i]);
        end
        cb = ~c ^ (corrupt ? 8'h01 : 8'h00);
        put_byte(cb);
        rem = crc_byte(c, cb);
    endtask

    task automatic t_reset();
        chk({byte_valid, crc_err, inv_frame, rx_disabled} == 4'b0, "R1 reset outputs",
            {byte_valid, crc_err, inv_frame, rx_disabled}, 0);
        put_sym(3'd7);
        chk({c_bv, c_crc, c_inv, c_dis} == 4'b0, "R1 reserved code ignored",
            {c_bv, c_crc, c_inv, c_dis}, 0);
    endtask

    task automatic t_good_frame();
        logic [7:0] rem;
        buf8[0] = 8'h68; buf8[1] = 8'h6A; buf8[2] = 8'hF1;
        clr_seen();
        put_sym(C_SOF);
        put_seg(3, 0, rem);
        put_sym(C_EOD);
        chk(c_crc == (rem != 8'hC4), "R3 good CRC at end of data", c_crc, rem != 8'hC4);
        chk(seen_inv == 0 && !c_dis, "R3 good frame clean", seen_inv, 0);
        put_sym(C_EOF);
        chk(!c_dis, "R11 idle after frame", c_dis, 0);
    endtask

    task automatic t_bad_crc();
        logic [7:0] rem;
        buf8[0] = 8'h81; buf8[1] = 8'h3C;
        put_sym(C_SOF);
        put_seg(2, 1, rem);
        put_sym(C_EOD);
        chk(c_crc == 1'b1 && rem != 8'hC4, "R3 corrupt CRC flagged", c_crc, 1);
        chk(c_dis, "R11 lockout after CRC error", c_dis, 1);
        clr_seen();
        put_byte(8'hA5);
        put_sym(C_SOF);
        put_sym(C_EOD);
        chk(seen_bv == 0 && seen_crc == 0 && seen_inv == 0, "R11 silent while locked",
            seen_bv + seen_crc + seen_inv, 0);
        put_sym(C_EOF);
        chk(!c_dis, "R11 end of frame releases", c_dis, 1'b0);
    endtask

    task automatic t_response(input bit corrupt);
        logic [7:0] rem;
        buf8[0] = 8'h11; buf8[1] = 8'h22;
        put_sym(C_SOF);
        put_seg(2, 0, rem);
        put_sym(C_EOD);
        put_sym(C_NB);
        buf8[0] = 8'h5E;
        put_seg(1, corrupt, rem);
        put_sym(C_EOD);
        chk(c_crc == corrupt && c_crc == (rem != 8'hC4), "R4 response CRC", c_crc, corrupt);
        put_sym(C_EOF);
    endtask

    task automatic t_sof_after_eod();
        logic [7:0] rem;
        buf8[0] = 8'h42;
        put_sym(C_SOF);
        put_seg(1, 0, rem);
        put_sym(C_EOD);
        put_sym(C_SOF);
        chk(c_inv && c_dis, "R5 SOF after end of data", c_inv, 1);
        put_sym(C_EOF);
    endtask

    task automatic t_sof_in_data();
        put_sym(C_SOF);
        put_sym(C_B1); put_sym(C_B0); put_sym(C_B1);
        put_sym(C_SOF);
        chk(c_inv, "R6 SOF while data expected", c_inv, 1);
        put_sym(C_EOF);
        put_sym(C_SOF);
        put_byte(8'h0F);
        put_sym(C_NB);
        chk(c_inv, "R6 NB while data expected", c_inv, 1);
        put_sym(C_EOF);
    endtask

    task automatic t_length(input bit unlim);
        len_unlimited = unlim;
        clr_seen();
        put_sym(C_SOF);
        for (int i = 0; i < 12; i++) put_byte(8'(i + 3));
        chk(seen_inv == 0, "R7 twelve bytes allowed", seen_inv, 0);
        put_byte(8'hC3);
        if (unlim)
            chk(seen_inv == 0 && c_bv && c_bd == 8'hC3, "R7 unlimited 13th byte", c_bd, 8'hC3);
        else
            chk(seen_inv == 1 && seen_bv == 12, "R7 13th byte rejected", seen_inv, 1);
        put_sym(C_EOF);
        len_unlimited = 1'b0;
    endtask

    task automatic t_partial_eod();
        put_sym(C_SOF);
        put_byte(8'h99);
        put_sym(C_B0);
        put_sym(C_EOD);
        chk(c_inv && !c_crc, "R8 end of data mid byte", c_inv, 1);
        put_sym(C_EOF);
        put_sym(C_SOF);
        put_sym(C_EOD);
        chk(c_inv, "R8 end of data with no byte", c_inv, 1);
        put_sym(C_EOF);
    endtask

    task automatic t_bit_idle();
        put_sym(C_B1);
        chk(c_inv && c_dis, "R9 data bit while idle", c_inv, 1);
        put_sym(C_EOF);
        buf8[0] = 8'h77;
        begin
            logic [7:0] rem;
            put_sym(C_SOF);
            put_seg(1, 0, rem);
        end
        put_sym(C_EOD);
        put_sym(C_B0);
        chk(c_inv, "R9 data bit after end of data", c_inv, 1);
        put_sym(C_EOF);
    endtask

    task automatic t_second_eod();
        logic [7:0] rem;
        buf8[0] = 8'h3A;
        put_sym(C_SOF); put_seg(1, 0, rem); put_sym(C_EOD);
        put_sym(C_NB); put_seg(1, 0, rem); put_sym(C_EOD);
        put_sym(C_NB);
        chk(c_inv, "R10 symbol after second end of data", c_inv, 1);
        put_sym(C_EOF);
        clr_seen();
        put_sym(C_SOF); put_seg(1, 0, rem); put_sym(C_EOD);
        put_sym(C_EOD);
        put_sym(C_EOF);
        chk(seen_inv == 0 && !c_dis, "R10 second end of data then EOF", seen_inv, 0);
    endtask

    task automatic t_break();
        put_sym(C_SOF);
        put_sym(C_B1); put_sym(C_B1);
        clr_seen();
        put_sym(C_BRK);
        chk(c_dis && !c_inv && !c_crc, "R12 break locks silently", {c_dis, c_inv, c_crc}, 3'b100);
        put_byte(8'hFF);
        chk(seen_bv == 0 && seen_inv == 0, "R12 no data after break", seen_bv, 0);
        put_sym(C_EOF);
        chk(!c_dis, "R12 EOF clears break lockout", c_dis, 0);
    endtask

    task automatic t_quiet();
        logic [7:0] rem;
        quiet_mode = 1'b1; tx_active = 1'b0;
        buf8[0] = 8'hE0;
        put_sym(C_SOF); put_seg(1, 1, rem); put_sym(C_EOD);
        chk(!c_crc && c_dis, "R13 quiet mutes CRC error", {c_crc, c_dis}, 2'b01);
        put_sym(C_EOF);
        put_sym(C_B0);
        chk(!c_inv && c_dis, "R13 quiet mutes invalid frame", {c_inv, c_dis}, 2'b01);
        put_sym(C_EOF);
        tx_active = 1'b1;
        put_sym(C_SOF); put_seg(1, 1, rem); put_sym(C_EOD);
        chk(c_crc, "R13 transmitting keeps CRC error", c_crc, 1);
        put_sym(C_EOF);
        quiet_mode = 1'b0; tx_active = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        t_reset();
        t_good_frame();
        t_bad_crc();
        t_response(0);
        t_response(1);
        t_sof_after_eod();
        t_sof_in_data();
        t_length(0);
        t_length(1);
        t_partial_eod();
        t_bit_idle();
        t_second_eod();
        t_break();
        t_quiet();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule